// File: doc/BRIEF.md
# Quad Fractional Word Load Unpacker

This block sits between the data-memory read return path and the data register file. A 64-bit read of a quad word is offered with its byte address, an endian mode bit and four destination register indices. The block splits the bus into four signed 16-bit fractional words ordered by memory address. It widens each word into a 40-bit register image and presents all four register writes together one cycle later.

Lane selection depends on the endian mode bit, so the word at the lowest address always reaches the first destination. The address must be quad aligned. A misaligned read raises a one-cycle fault and writes nothing. Each write also clears the destination's limit tag. When two destinations name the same register, the operand later in the first-to-fourth order wins.

The input side is a valid/ready stream whose ready is held high at all times. The register file cannot stall, so there is no back-pressure: a beat with `in_valid` high is consumed on that clock edge. The write ports and the fault flag are plain strobes that last one cycle.

Top module: `quad_word_unpacker`

## Requirements
- R1: `in_ready` is high in every cycle, including during reset, so every beat with `in_valid` high is accepted on the clock edge where it is presented.
- R2: An accepted beat with `in_addr[2:0] == 0` drives its write enables high in the next cycle only. A cycle with no accepted aligned beat leaves all enables low in the following cycle.
- R3: Each written 40-bit value has bits 31:16 equal to the source word, bits 39:32 equal to copies of the word's bit 15, and bits 15:0 equal to zero.
- R4: With `in_big_endian = 0`, port k receives the word at byte address +2k, taken from bus bits 16k+15:16k. The byte at the lower address is the word's low byte.
- R5: With `in_big_endian = 1`, port k receives the word at byte address +2k, taken from bus bits 63-16k:48-16k. The byte at the lower address is the word's high byte.
- R6: An accepted beat with `in_addr[2:0] != 0` raises `align_fault` for exactly the next cycle, and all write enables stay low in that cycle.
- R7: `wr_tag_clr[k]` is high exactly when `wr_en[k]` is high, so every written destination has its limit tag cleared.
- R8: If two destination indices are equal, only the port later in the order 0..3 writes it. The enable of the earlier port is dropped, so no two enabled ports ever share an index.
- R9: While reset is asserted, and in the first cycle after it, `align_fault` and all write enables are low.
- R10: `wr_idx` field k (bits 4k+3:4k) carries destination index field k of the accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Read data beat present |
| in_ready | output | 1 | Always high; the block never stalls |
| in_addr | input | 32 | Byte address of the quad word |
| in_big_endian | input | 1 | 1 = big endian lane map, 0 = little endian |
| in_data | input | 64 | Read data bus |
| in_dst_idx | input | 16 | Four 4-bit destination indices, operand k in bits 4k+3:4k |
| wr_en | output | 4 | Per-port register write enables |
| wr_idx | output | 16 | Per-port destination indices |
| wr_data | output | 160 | Per-port 40-bit register values, port k in bits 40k+39:40k |
| wr_tag_clr | output | 4 | Per-port limit tag clear strobes |
| align_fault | output | 1 | One-cycle misalignment fault |

## Verification
The assertions check the following on every cycle:
- an aligned beat produces a write on the last port one cycle later;
- a misaligned beat produces a fault with no writes;
- an idle cycle produces nothing;
- enabled ports never share an index;
- every enabled value carries zero fill below and a consistent sign field above.

Only the bench's reference model can show that each word comes from the correct bus lane in both endian modes, that the middle field equals the exact source word, and which port survives when indices collide.

// File: rtl/qwu_pkg.sv
package qwu_pkg;
  parameter int QWU_LANES  = 4;
  parameter int QWU_WORD_W = 16;
  parameter int QWU_REG_W  = 40;
  parameter int QWU_FRAC_LSB = 16;
  parameter int QWU_IDX_W  = 4;
  parameter int QWU_ADDR_W = 32;

  typedef enum logic {
    LANE_LITTLE = 1'b0,
    LANE_BIG    = 1'b1
  } lane_order_e;
endpackage

// File: rtl/qwu_lane_select.sv
module qwu_lane_select #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16,
  localparam int BUS_W = LANES * WORD_W
) (
  input  logic             big_endian,
  input  logic [BUS_W-1:0] bus,
  output logic [BUS_W-1:0] words
);
  import qwu_pkg::*;

  lane_order_e order;
  assign order = lane_order_e'(big_endian);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WORD_W-1:0] from_low;
    logic [WORD_W-1:0] from_high;
    assign from_low  = bus[k*WORD_W +: WORD_W];
    assign from_high = bus[(LANES-1-k)*WORD_W +: WORD_W];
    assign words[k*WORD_W +: WORD_W] = (order == LANE_BIG) ? from_high : from_low;
  end
endmodule

// File: rtl/qwu_word_expand.sv
module qwu_word_expand #(
  parameter int WORD_W   = 16,
  parameter int REG_W    = 40,
  parameter int FRAC_LSB = 16,
  localparam int EXT_W   = REG_W - WORD_W - FRAC_LSB
) (
  input  logic [WORD_W-1:0] word,
  output logic [REG_W-1:0]  value
);
  assign value = {{EXT_W{word[WORD_W-1]}}, word, {FRAC_LSB{1'b0}}};
endmodule

// File: rtl/qwu_align_check.sv
module qwu_align_check #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              misaligned
);
  logic unused_addr_hi;
  assign unused_addr_hi = ^addr[ADDR_W-1:ALIGN_BITS];
  assign misaligned = |addr[ALIGN_BITS-1:0];
endmodule

// File: rtl/qwu_dup_mask.sv
module qwu_dup_mask #(
  parameter int LANES = 4,
  parameter int IDX_W = 4
) (
  input  logic [LANES*IDX_W-1:0] idx,
  output logic [LANES-1:0]       keep
);
  always_comb begin
    keep = '1;
    for (int i = 0; i < LANES; i++) begin
      for (int j = i + 1; j < LANES; j++) begin
        if (idx[i*IDX_W +: IDX_W] == idx[j*IDX_W +: IDX_W]) keep[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/quad_word_unpacker.sv
module quad_word_unpacker #(
  parameter int LANES    = qwu_pkg::QWU_LANES,
  parameter int WORD_W   = qwu_pkg::QWU_WORD_W,
  parameter int REG_W    = qwu_pkg::QWU_REG_W,
  parameter int FRAC_LSB = qwu_pkg::QWU_FRAC_LSB,
  parameter int IDX_W    = qwu_pkg::QWU_IDX_W,
  parameter int ADDR_W   = qwu_pkg::QWU_ADDR_W,
  localparam int BUS_W   = LANES * WORD_W,
  localparam int ALIGN_BITS = $clog2(BUS_W / 8)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic                   in_big_endian,
  input  logic [BUS_W-1:0]       in_data,
  input  logic [LANES*IDX_W-1:0] in_dst_idx,
  output logic [LANES-1:0]       wr_en,
  output logic [LANES*IDX_W-1:0] wr_idx,
  output logic [LANES*REG_W-1:0] wr_data,
  output logic [LANES-1:0]       wr_tag_clr,
  output logic                   align_fault
);
  logic [BUS_W-1:0]       words;
  logic [LANES*REG_W-1:0] expanded;
  logic [LANES-1:0]       keep;
  logic                   misaligned;
  logic                   accept;
  logic                   go;

  assign in_ready = 1'b1;
  assign accept   = in_valid & in_ready;
  assign go       = accept & ~misaligned;

  qwu_align_check #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
    .addr(in_addr), .misaligned(misaligned));

  qwu_lane_select #(.LANES(LANES), .WORD_W(WORD_W)) u_lanes (
    .big_endian(in_big_endian), .bus(in_data), .words(words));

  for (genvar k = 0; k < LANES; k++) begin : g_expand
    qwu_word_expand #(.WORD_W(WORD_W), .REG_W(REG_W), .FRAC_LSB(FRAC_LSB)) u_exp (
      .word(words[k*WORD_W +: WORD_W]), .value(expanded[k*REG_W +: REG_W]));
  end

  qwu_dup_mask #(.LANES(LANES), .IDX_W(IDX_W)) u_dup (
    .idx(in_dst_idx), .keep(keep));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en       <= '0;
      align_fault <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
    end else begin
      wr_en       <= go ? keep : '0;
      align_fault <= accept & misaligned;
      if (go) begin
        wr_idx  <= in_dst_idx;
        wr_data <= expanded;
      end
    end
  end

  assign wr_tag_clr = wr_en;

  // R2: an aligned beat always lands at least on the last port
  p_aligned_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !misaligned) |=> (wr_en[LANES-1] && !align_fault));

  // R2: nothing comes out after an idle cycle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (wr_en == '0 && !align_fault));

  // R6: misaligned beat faults and writes nothing
  p_misalign_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && misaligned) |=> (align_fault && wr_en == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R3: zero fill below, uniform sign field above
    p_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |-> (wr_data[i*REG_W +: FRAC_LSB] == '0 &&
        (wr_data[i*REG_W + FRAC_LSB + WORD_W - 1 +: REG_W - FRAC_LSB - WORD_W + 1] == '0 ||
         wr_data[i*REG_W + FRAC_LSB + WORD_W - 1 +: REG_W - FRAC_LSB - WORD_W + 1] == '1)));
    for (genvar j = i + 1; j < LANES; j++) begin : g_pair
      // R8: enabled ports never share a destination
      p_unique_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[i] && wr_en[j]) |-> (wr_idx[i*IDX_W +: IDX_W] != wr_idx[j*IDX_W +: IDX_W]));
    end
  end
endmodule

// File: tb/test_quad_word_unpacker.sv
`timescale 1ns/1ps
module test_quad_word_unpacker;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_addr = '0;
  logic         in_big_endian = 1'b0;
  logic [63:0]  in_data = '0;
  logic [15:0]  in_dst_idx = '0;
  logic [3:0]   wr_en;
  logic [15:0]  wr_idx;
  logic [159:0] wr_data;
  logic [3:0]   wr_tag_clr;
  logic         align_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  quad_word_unpacker i_quad_word_unpacker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_big_endian(in_big_endian), .in_data(in_data),
    .in_dst_idx(in_dst_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_tag_clr(wr_tag_clr), .align_fault(align_fault));

  // behavioural reference model
  logic [3:0]  exp_en = '0;
  logic        exp_fault = 1'b0;
  logic [39:0] exp_data [4];
  logic [3:0]  exp_idx  [4];
  logic        exp_big = 1'b0;
  bit          model_live = 1'b0;

  function automatic logic [7:0] bus_byte(logic [63:0] d, bit big, int n);
    return big ? d[63 - 8*n -: 8] : d[8*n +: 8];
  endfunction

  always @(posedge clk) begin
    model_live = 1'b1;
    if (!rst_n) begin
      exp_en = '0;
      exp_fault = 1'b0;
    end else begin
      exp_fault = in_valid && (in_addr % 8 != 0);
      if (in_valid && (in_addr % 8 == 0)) begin
        exp_big = in_big_endian;
        for (int k = 0; k < 4; k++) begin
          logic [15:0] w;
          longint s;
          if (in_big_endian) w = {bus_byte(in_data, 1'b1, 2*k), bus_byte(in_data, 1'b1, 2*k+1)};
          else               w = {bus_byte(in_data, 1'b0, 2*k+1), bus_byte(in_data, 1'b0, 2*k)};
          s = longint'($signed(w)) * 65536;
          exp_data[k] = s[39:0];
          exp_idx[k]  = in_dst_idx[4*k +: 4];
          exp_en[k]   = 1'b1;
          for (int j = k + 1; j < 4; j++)
            if (in_dst_idx[4*j +: 4] == in_dst_idx[4*k +: 4]) exp_en[k] = 1'b0;
        end
      end else begin
        exp_en = '0;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (model_live && !done) begin
      chk("R1 ready", 64'(in_ready), 64'd1);
      chk(rst_n ? "R2/R8 enables" : "R9 reset enables", 64'(wr_en), 64'(exp_en));
      chk(rst_n ? "R6 fault" : "R9 reset fault", 64'(align_fault), 64'(exp_fault));
      chk("R7 tag clear", 64'(wr_tag_clr), 64'(exp_en));
      for (int k = 0; k < 4; k++) begin
        if (exp_en[k]) begin
          chk(exp_big ? "R3/R5 data" : "R3/R4 data", 64'(wr_data[40*k +: 40]), 64'(exp_data[k]));
          chk("R10 index", 64'(wr_idx[4*k +: 4]), 64'(exp_idx[k]));
        end
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic beat(bit v, logic [31:0] a, bit big, logic [63:0] d, logic [15:0] idx);
    @(negedge clk);
    #0.5;
    in_valid = v; in_addr = a; in_big_endian = big; in_data = d; in_dst_idx = idx;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5;
    rst_n = 1'b1;
    // R4 little endian, mixed signs
    beat(1, 32'h0000_1000, 0, 64'h8000_7FFF_FFFF_0001, 16'h3210);
    beat(1, 32'h0000_1008, 0, 64'h1234_5678_9ABC_DEF0, 16'h7654);
    // R5 big endian, same data
    beat(1, 32'h0000_1010, 1, 64'h8000_7FFF_FFFF_0001, 16'h3210);
    beat(1, 32'hFFFF_FFF8, 1, 64'h1234_5678_9ABC_DEF0, 16'hFEDC);
    // idle gap then R6 each misaligned offset, both modes
    beat(0, 32'h0, 0, 64'h0, 16'h0);
    for (int off = 1; off < 8; off++)
      beat(1, 32'h0000_2000 + 32'(off), off % 2, 64'hDEAD_BEEF_0BAD_F00D, 16'h3210);
    // R8 duplicate destinations
    beat(1, 32'h40, 0, 64'h0004_0003_0002_0001, 16'h5555);
    beat(1, 32'h48, 1, 64'h0004_0003_0002_0001, 16'h1231);
    beat(1, 32'h50, 0, 64'hF000_0FFF_8001_7FFE, 16'h9889);
    // aligned directly after misaligned and vice versa
    beat(1, 32'h61, 0, 64'h1, 16'h0123);
    beat(1, 32'h68, 0, 64'h0, 16'hABCD);
    beat(1, 32'h6C, 1, 64'h1, 16'hABCD);
    beat(0, 32'h0, 0, 64'h0, 16'h0);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom % 2 == 0) a[2:0] = 3'b000;
      beat(($urandom % 4) != 0, a, $urandom % 2,
           {$urandom, $urandom}, 16'($urandom));
    end
    // reset mid-stream: R9
    beat(1, 32'h80, 0, 64'h5, 16'h3210);
    @(negedge clk); #0.5;
    rst_n = 1'b0;
    in_valid = 1'b1; in_addr = 32'h88;
    repeat (2) @(negedge clk);
    #0.5;
    rst_n = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule